// File: doc/BRIEF.md
# Homing Completion Qualifier

This block decides when a motion axis has finished its return-to-origin move. A start pulse arms it. It then watches an origin sensor level, which a neighbouring block has already conditioned. In the simple mode the axis counts as homed as soon as the origin sensor is active. In the combined mode it counts as homed only after a programmed number of encoder index edges have been seen while the origin sensor stays active. The counted edge polarity is selectable, and the required count is written as the number of edges minus one.

The encoder A, B and index inputs pass through an optional noise filter. The filter rejects any level that lasts fewer than three clocks. The filtered levels are brought out, and the filtered index level also serves as a status bit. On completion the block gives three outputs:
- a one-cycle completion strobe;
- if enabled, a one-cycle position-counter reset strobe;
- if enabled, a deviation-counter-clear (ERC) pulse of a fixed number of clocks.

The state machine has four states:
- IDLE is the state after reset.
- WAIT_ORG waits for the origin sensor.
- COUNT_Z counts index edges.
- DONE holds the completion level.

The transitions are:
- IDLE→WAIT_ORG on start.
- WAIT_ORG→DONE when the origin sensor is active in mode 0.
- WAIT_ORG→COUNT_Z when the origin sensor is active in mode 1.
- COUNT_Z→WAIT_ORG when the origin sensor drops.
- COUNT_Z→DONE on the final qualifying edge.
- DONE→WAIT_ORG on start, which begins a new sequence.

Top module: `homing_qualifier`

## Requirements
- R1: After reset the block is in IDLE and every output is 0.
- R2: start_i moves IDLE or DONE to WAIT_ORG and clears done_o on the next clock edge. start_i has no effect in WAIT_ORG or COUNT_Z: an active count still completes on its programmed edge.
- R3: With mode_z_i=0, an active org_i sampled in WAIT_ORG completes the sequence. done_stb_o and done_o are high in the cycle after that edge.
- R4: With mode_z_i=1, an active org_i in WAIT_ORG enters COUNT_Z. Completion happens on qualifying index edge number z_cnt_m1_i+1 (1 to 16 edges) seen in COUNT_Z. Edges seen in other states are not counted.
- R5: With z_fall_i=0 only 0→1 transitions of the filtered index count. With z_fall_i=1 only 1→0 transitions count. A counted edge acts on the clock edge after the filtered index changes.
- R6: If org_i is low in COUNT_Z, the block returns to WAIT_ORG and the edge count restarts from zero.
- R7: With filt_en_i=1, a filtered output takes a new level only when the raw input has held that level for 3 consecutive sampling edges. The output changes on the third of those edges. With filt_en_i=0 the output follows the raw input one clock later.
- R8: done_stb_o is high for exactly one cycle per completion. done_o stays high from completion until the next start_i.
- R9: pos_clr_o pulses for one cycle, together with done_stb_o, only when clr_en_i=1.
- R10: When erc_en_i=1, erc_o is high for exactly ERC_LEN cycles, starting with the completion strobe.
- R11: z_level_o reports the filtered index level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Arms a new homing sequence |
| mode_z_i | input | 1 | 0: origin only, 1: origin plus index edges |
| z_fall_i | input | 1 | 0: count rising index edges, 1: count falling |
| z_cnt_m1_i | input | CNT_W | Required index edges minus one |
| filt_en_i | input | 1 | Enables the encoder noise filter |
| clr_en_i | input | 1 | Enables the position-counter reset strobe |
| erc_en_i | input | 1 | Enables the ERC pulse |
| org_i | input | 1 | Conditioned origin sensor, active high |
| enc_a_i | input | 1 | Raw encoder A |
| enc_b_i | input | 1 | Raw encoder B |
| enc_z_i | input | 1 | Raw encoder index |
| enc_a_o | output | 1 | Filtered encoder A |
| enc_b_o | output | 1 | Filtered encoder B |
| z_level_o | output | 1 | Filtered index level (status) |
| done_o | output | 1 | Homing complete level |
| done_stb_o | output | 1 | One-cycle completion strobe |
| pos_clr_o | output | 1 | One-cycle position-counter reset |
| erc_o | output | 1 | Deviation-counter-clear pulse |

## Verification
A wrong edge count or a missed return to WAIT_ORG shows at the ports as done_stb_o arriving one or more index edges early or late, or not arriving at all. The bench therefore compares every output against a cycle-level model on every clock, so any slip is reported in the cycle it appears. A filter that rejects too little or too much shows up on z_level_o and the A/B outputs within one clock of the third sampling edge. A stray index edge then reaches the count one clock later.

// File: rtl/homing_pkg.sv
package homing_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_ORG = 2'd1,
        ST_COUNT_Z  = 2'd2,
        ST_DONE     = 2'd3
    } home_state_t;
endpackage

// File: rtl/homing_noise_filter.sv
module homing_noise_filter #(
    parameter int LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic raw_i,
    output logic out_o
);
    localparam int HW = (LEN > 1) ? LEN - 1 : 1;

    logic [HW-1:0] hist_q;
    logic          out_q;
    logic          all_high;
    logic          all_low;

    assign all_high = raw_i & (&hist_q);
    assign all_low  = ~raw_i & ~(|hist_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
            out_q  <= 1'b0;
        end else begin
            hist_q <= (hist_q << 1) | HW'(raw_i);
            if (!en_i)         out_q <= raw_i;
            else if (all_high) out_q <= 1'b1;
            else if (all_low)  out_q <= 1'b0;
        end
    end

    assign out_o = out_q;

    AST_FILTER_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en_i) && (out_q != $past(out_q))) |-> (out_q == $past(raw_i))); // R7
endmodule

// File: rtl/homing_edge_pick.sv
module homing_edge_pick (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic fall_sel_i,
    output logic edge_o
);
    logic prev_q;
    logic rise;
    logic fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level_i;
    end

    assign rise   = level_i & ~prev_q;
    assign fall   = ~level_i & prev_q;
    assign edge_o = fall_sel_i ? fall : rise;

    AST_EDGE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_o && !fall_sel_i) |=> (fall_sel_i || !edge_o)); // R5
endmodule

// File: rtl/homing_erc_pulse.sv
module homing_erc_pulse #(
    parameter int LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic pulse_o
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (fire_i)        cnt_q <= CW'(LEN);
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign pulse_o = (cnt_q != '0);

    AST_ERC_FROM_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |-> $past(fire_i)); // R10
endmodule

// File: rtl/homing_qualifier.sv
module homing_qualifier #(
    parameter int CNT_W    = 4,
    parameter int FILT_LEN = 3,
    parameter int ERC_LEN  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             mode_z_i,
    input  logic             z_fall_i,
    input  logic [CNT_W-1:0] z_cnt_m1_i,
    input  logic             filt_en_i,
    input  logic             clr_en_i,
    input  logic             erc_en_i,
    input  logic             org_i,
    input  logic             enc_a_i,
    input  logic             enc_b_i,
    input  logic             enc_z_i,
    output logic             enc_a_o,
    output logic             enc_b_o,
    output logic             z_level_o,
    output logic             done_o,
    output logic             done_stb_o,
    output logic             pos_clr_o,
    output logic             erc_o
);
    import homing_pkg::*;

    localparam int NCH   = 3;
    localparam int CH_Z  = 2;

    logic [NCH-1:0] raw_bus;
    logic [NCH-1:0] filt_bus;
    logic           z_edge;

    home_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             complete;
    logic             done_q, stb_q, clr_q;

    assign raw_bus = {enc_z_i, enc_b_i, enc_a_i};

    for (genvar g = 0; g < NCH; g++) begin : g_filt
        homing_noise_filter #(.LEN(FILT_LEN)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .en_i  (filt_en_i),
            .raw_i (raw_bus[g]),
            .out_o (filt_bus[g])
        );
    end

    homing_edge_pick u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .level_i    (filt_bus[CH_Z]),
        .fall_sel_i (z_fall_i),
        .edge_o     (z_edge)
    );

    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        complete = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_WAIT_ORG;
            end
            ST_WAIT_ORG: begin
                cnt_d = '0;
                if (org_i) begin
                    if (mode_z_i) begin
                        state_d = ST_COUNT_Z;
                    end else begin
                        state_d  = ST_DONE;
                        complete = 1'b1;
                    end
                end
            end
            ST_COUNT_Z: begin
                if (!org_i) begin
                    state_d = ST_WAIT_ORG;
                    cnt_d   = '0;
                end else if (z_edge) begin
                    if (cnt_q == z_cnt_m1_i) begin
                        state_d  = ST_DONE;
                        complete = 1'b1;
                        cnt_d    = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_DONE: begin
                if (start_i) state_d = ST_WAIT_ORG;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            stb_q  <= 1'b0;
            clr_q  <= 1'b0;
        end else begin
            done_q <= (state_d == ST_DONE);
            stb_q  <= complete;
            clr_q  <= complete & clr_en_i;
        end
    end

    homing_erc_pulse #(.LEN(ERC_LEN)) u_erc (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (complete & erc_en_i),
        .pulse_o (erc_o)
    );

    assign enc_a_o    = filt_bus[0];
    assign enc_b_o    = filt_bus[1];
    assign z_level_o  = filt_bus[CH_Z];
    assign done_o     = done_q;
    assign done_stb_o = stb_q;
    assign pos_clr_o  = clr_q;

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_stb_o |=> !done_stb_o); // R8
    AST_STROBE_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_stb_o |-> done_o); // R8
    AST_CLR_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        pos_clr_o |-> done_stb_o); // R9
    AST_ORG_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT_Z && !org_i) |=> (state_q == ST_WAIT_ORG)); // R6
    AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT_Z && org_i && !z_edge) |=> (state_q == ST_COUNT_Z)); // R2
    AST_MODE0_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_ORG && org_i && !mode_z_i) |=> done_stb_o); // R3
endmodule

// File: tb/homing_qualifier_tb.sv
module homing_qualifier_tb;
    localparam int CNT_W   = 4;
    localparam int ERC_LEN = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 0, mode_z_i = 0, z_fall_i = 0, filt_en_i = 0;
    logic clr_en_i = 0, erc_en_i = 0, org_i = 0;
    logic enc_a_i = 0, enc_b_i = 0, enc_z_i = 0;
    logic [CNT_W-1:0] z_cnt_m1_i = '0;
    logic enc_a_o, enc_b_o, z_level_o, done_o, done_stb_o, pos_clr_o, erc_o;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    homing_qualifier #(.CNT_W(CNT_W), .FILT_LEN(3), .ERC_LEN(ERC_LEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_z_i(mode_z_i),
        .z_fall_i(z_fall_i), .z_cnt_m1_i(z_cnt_m1_i), .filt_en_i(filt_en_i),
        .clr_en_i(clr_en_i), .erc_en_i(erc_en_i), .org_i(org_i),
        .enc_a_i(enc_a_i), .enc_b_i(enc_b_i), .enc_z_i(enc_z_i),
        .enc_a_o(enc_a_o), .enc_b_o(enc_b_o), .z_level_o(z_level_o),
        .done_o(done_o), .done_stb_o(done_stb_o), .pos_clr_o(pos_clr_o), .erc_o(erc_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference model, states 0 IDLE, 1 WAIT_ORG, 2 COUNT_Z, 3 DONE
    int         m_state;
    int         m_cnt;
    int         m_erc;
    logic [2:0] m_h1, m_h2, m_fo;
    logic       m_zprev, m_stb, m_clr, m_done;

    function automatic logic edge_of(input logic lvl, input logic prev, input logic fall);
        return fall ? (!lvl && prev) : (lvl && !prev);
    endfunction

    always @(posedge clk) begin
        logic [2:0] raw;
        logic       edg, comp;
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_erc = 0;
            m_h1 = '0; m_h2 = '0; m_fo = '0;
            m_zprev = 0; m_stb = 0; m_clr = 0; m_done = 0;
        end else begin
            raw = {enc_z_i, enc_b_i, enc_a_i};
            edg = edge_of(m_fo[2], m_zprev, z_fall_i);
            m_zprev = m_fo[2];
            for (int c = 0; c < 3; c++) begin
                if (!filt_en_i) m_fo[c] = raw[c];
                else if (raw[c] == m_h1[c] && raw[c] == m_h2[c]) m_fo[c] = raw[c];
            end
            m_h2 = m_h1;
            m_h1 = raw;
            comp = 0;
            case (m_state)
                0: if (start_i) m_state = 1;
                1: begin
                    m_cnt = 0;
                    if (org_i) begin
                        if (mode_z_i) m_state = 2;
                        else begin m_state = 3; comp = 1; end
                    end
                end
                2: begin
                    if (!org_i) begin m_state = 1; m_cnt = 0; end
                    else if (edg) begin
                        if (m_cnt == int'(z_cnt_m1_i)) begin m_state = 3; comp = 1; m_cnt = 0; end
                        else m_cnt++;
                    end
                end
                default: if (start_i) m_state = 1;
            endcase
            m_stb = comp;
            m_clr = comp & clr_en_i;
            if (comp && erc_en_i) m_erc = ERC_LEN;
            else if (m_erc > 0) m_erc--;
            m_done = (m_state == 3);
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check("R7", "enc_a_o", enc_a_o, m_fo[0]);
            check("R7", "enc_b_o", enc_b_o, m_fo[1]);
            check("R11", "z_level_o", z_level_o, m_fo[2]);
            check("R2", "done_o", done_o, m_done);
            check("R8", "done_stb_o", done_stb_o, m_stb);
            check("R9", "pos_clr_o", pos_clr_o, m_clr);
            check("R10", "erc_o", erc_o, m_erc > 0);
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse_start();
        start_i = 1; tick(); start_i = 0;
    endtask

    task automatic z_pulse();
        enc_z_i = 1; tick(); tick(); enc_z_i = 0; tick(); tick();
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        summary();
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd20240611));
        tick(); tick();
        // R1 reset state
        check("R1", "reset outputs", {done_o, done_stb_o, pos_clr_o, erc_o, z_level_o, enc_a_o, enc_b_o}, 7'd0);
        rst_n = 1;
        tick();
        check("R1", "idle after reset", {done_o, done_stb_o}, 2'b00);

        // R3, R8, R9, R10 origin-only completion
        mode_z_i = 0; clr_en_i = 1; erc_en_i = 1;
        pulse_start();
        org_i = 1; tick();
        check("R3", "strobe after origin", done_stb_o, 1'b1);
        check("R9", "pos clear", pos_clr_o, 1'b1);
        check("R8", "done level", done_o, 1'b1);
        org_i = 0;
        n = 1;
        tick();
        check("R8", "strobe single", done_stb_o, 1'b0);
        check("R9", "pos clear single", pos_clr_o, 1'b0);
        while (erc_o && n < 50) begin n++; tick(); end
        check("R10", "erc length", n, ERC_LEN);
        check("R8", "done held", done_o, 1'b1);

        // R4 16 rising edges, with an ignored start in the middle (R2)
        mode_z_i = 1; z_fall_i = 0; z_cnt_m1_i = 4'd15; clr_en_i = 0; erc_en_i = 0;
        pulse_start();
        check("R2", "start leaves done", done_o, 1'b0);
        org_i = 1; tick();
        for (int i = 0; i < 15; i++) begin
            z_pulse();
            if (i == 7) pulse_start();
        end
        check("R4", "15 of 16 edges", done_o, 1'b0);
        enc_z_i = 1; tick(); tick();
        check("R4", "16th edge completes", done_stb_o, 1'b1);
        check("R9", "no clear when disabled", pos_clr_o, 1'b0);
        enc_z_i = 0; tick(); tick();

        // R5 falling polarity, single edge
        z_cnt_m1_i = 4'd0; z_fall_i = 1;
        pulse_start();
        tick();
        enc_z_i = 1; tick(); tick(); tick();
        check("R5", "rising ignored when falling selected", done_o, 1'b0);
        enc_z_i = 0; tick(); tick();
        check("R5", "falling edge completes", done_o, 1'b1);

        // R6 origin drop restarts count
        z_fall_i = 0; z_cnt_m1_i = 4'd2;
        pulse_start();
        tick();
        z_pulse(); z_pulse();
        org_i = 0; tick(); tick();
        org_i = 1; tick();
        z_pulse();
        check("R6", "count cleared by origin loss", done_o, 1'b0);
        z_pulse(); z_pulse();
        check("R6", "completes after fresh 3 edges", done_o, 1'b1);

        // R7, R11 filter
        org_i = 0; filt_en_i = 1;
        pulse_start();
        enc_z_i = 1; tick(); tick(); enc_z_i = 0;
        check("R7", "2-cycle z rejected", z_level_o, 1'b0);
        tick(); tick(); tick();
        enc_a_i = 1; tick(); enc_a_i = 0; tick();
        check("R7", "1-cycle a rejected", enc_a_o, 1'b0);
        enc_z_i = 1; tick(); tick();
        check("R11", "z not yet passed", z_level_o, 1'b0);
        tick();
        check("R11", "z passed on third edge", z_level_o, 1'b1);
        filt_en_i = 0; enc_z_i = 0; tick();
        check("R7", "bypass one clock", z_level_o, 1'b0);

        // Constrained random sequences checked against the model
        for (int s = 0; s < 150; s++) begin
            int dly;
            mode_z_i   = $urandom_range(0, 1);
            z_fall_i   = $urandom_range(0, 1);
            z_cnt_m1_i = CNT_W'($urandom_range(0, 3));
            filt_en_i  = $urandom_range(0, 1);
            clr_en_i   = $urandom_range(0, 1);
            erc_en_i   = $urandom_range(0, 1);
            org_i = 0;
            pulse_start();
            dly = $urandom_range(0, 10);
            for (int c = 0; c < 400; c++) begin
                if ($urandom_range(0, 3) == 0) enc_a_i = ~enc_a_i;
                if ($urandom_range(0, 3) == 0) enc_b_i = ~enc_b_i;
                if ($urandom_range(0, 2) == 0) enc_z_i = ~enc_z_i;
                if (c < dly) org_i = 0;
                else if (!org_i) org_i = ($urandom_range(0, 3) == 0);
                else org_i = ($urandom_range(0, 60) != 0);
                start_i = ($urandom_range(0, 80) == 0);
                tick();
                start_i = 0;
                if (done_o) break;
            end
            org_i = 0;
            repeat (12) tick();
        end

        summary();
        $finish;
    end
endmodule